// File: doc/BRIEF.md
# Epoch Seconds Clock

This block keeps a 32-bit time-of-day count in whole seconds, with the epoch at the start of 1904. A free-running elapsed-seconds counter advances once per second. The time it reports is the sum of that counter and a stored offset. The second boundary comes from a prescaler. The prescaler counts pulses on a clock-enable input and fires once every `TICKS_PER_SEC` enabled cycles. On that boundary the block also emits a one-cycle pulse that the interrupt logic of a power-management controller can latch.

The command decoder of the controller drives the block through two strobes.

- **Read command.** It is issued with an argument byte count, which must be zero. One cycle later the block returns the current time as four bytes packed most-significant first.
- **Write command.** It carries exactly four argument bytes, most-significant first. It does not load the counter. Instead it recomputes the offset so that the reported time equals the written value from that moment on.
- **Wrong counts.** A command with any other byte count is dropped.

Because the prescaler is never disturbed by commands, the one-second pulse keeps its phase across every write.

Top module: `epoch_seconds_clock`

## Requirements
- R1: After reset, `secTick` and `rspValid` are low. A read issued with no enable pulses returns `RESET_OFFSET`, which defaults to 2082844800 (the first second of 1970 counted from 1904).
- R2: `secTick` is high for exactly one cycle after every `TICKS_PER_SEC`-th cycle in which `tickEn` is high. Cycles with `tickEn` low do not advance the prescaler. `secTick` is never high unless `tickEn` was high in the previous cycle.
- R3: A read strobe with `getCount` equal to 0 raises `rspValid` for one cycle in the next cycle. In that cycle `rspData` carries the time of the strobe cycle, with the first response byte (most significant) in bits [31:24].
- R4: A read strobe with a non-zero `getCount` produces no `rspValid`, and `rspData` keeps its value.
- R5: A write strobe with `setCount` equal to 4 makes the reported time equal `setData` in the following cycle. The first argument byte (most significant) is taken from bits [31:24].
- R6: A write strobe with `setCount` other than 4 leaves the reported time unchanged.
- R7: A write does not shift the prescaler phase. The next `secTick` comes after the same number of enabled cycles as without the write.
- R8: A write in the same cycle as a second boundary still reports exactly the written value immediately afterwards. Counting resumes from the following boundary.
- R9: The reported time wraps modulo 2^32: after 0xFFFFFFFF, one second later it reads 0.
- R10: When no write is accepted, the reported time advances by exactly one for each `secTick` pulse and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Clock enable counted by the prescaler |
| setStb | input | 1 | Write-time command strobe |
| setCount | input | 3 | Argument byte count of the write command |
| setData | input | 32 | Written time, first byte in [31:24] |
| getStb | input | 1 | Read-time command strobe |
| getCount | input | 3 | Argument byte count of the read command |
| secTick | output | 1 | One-cycle pulse per elapsed second |
| rspValid | output | 1 | Read response valid, one cycle |
| rspData | output | 32 | Read response, first byte in [31:24] |

## Verification
On every cycle, the bound checker enforces four rules:

- The internal reported time either steps by the tick pulse or jumps to an accepted written value, and never moves otherwise.
- Accepted and rejected reads produce, or withhold, the response with the right payload.
- The tick pulse follows an enabled cycle.
- Where the division is larger than one, the tick pulse lasts a single cycle.

Three things can only be shown by the bench scenarios, where a model counts enabled cycles since reset:

- the exact spacing of the pulses across enable gaps;
- that a write leaves the pulse phase untouched, including a write on the boundary cycle itself;
- the reset epoch value and the wrap from all-ones to zero.

// File: rtl/epoch_clk_pkg.sv
package epoch_clk_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic secStep;     // a second boundary occurs at this edge
    logic loadOffset;  // accepted write: recompute the offset
    logic capture;     // accepted read: register the current time
  } clkStrobes_t;

endpackage

// File: rtl/epoch_clk_ctrl.sv
module epoch_clk_ctrl
  import epoch_clk_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned ARG_BYTES     = 4,
  parameter int unsigned CNT_W         = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             setStb,
  input  logic [CNT_W-1:0] setCount,
  input  logic             getStb,
  input  logic [CNT_W-1:0] getCount,
  output clkStrobes_t      strobes
);

  logic secStep;

  generate
    if (TICKS_PER_SEC <= 1) begin : g_noPrescale
      // Every enabled cycle is a full second.
      assign secStep = tickEn;
    end else begin : g_prescale
      localparam int unsigned PRE_W = $clog2(TICKS_PER_SEC);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);

      logic [PRE_W-1:0] preCnt;
      logic             atLast;

      assign atLast  = (preCnt == PRE_LAST);
      assign secStep = tickEn && atLast;

      // The next boundary is always counted from the previous one, so
      // commands never move the phase and no drift accumulates.
      always_ff @(posedge clk) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (tickEn) begin
          preCnt <= atLast ? '0 : preCnt + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    strobes.secStep    = secStep;
    strobes.loadOffset = setStb && (setCount == CNT_W'(ARG_BYTES));
    strobes.capture    = getStb && (getCount == '0);
  end

endmodule

// File: rtl/epoch_clk_datapath.sv
module epoch_clk_datapath
  import epoch_clk_pkg::*;
#(
  parameter int unsigned        TIME_W       = 32,
  parameter logic [TIME_W-1:0]  RESET_OFFSET = TIME_W'(2082844800)
) (
  input  logic              clk,
  input  logic              rstN,
  input  clkStrobes_t       strobes,
  input  logic [TIME_W-1:0] setData,
  output logic              secTick,
  output logic              rspValid,
  output logic [TIME_W-1:0] rspData,
  output logic [TIME_W-1:0] curTime
);

  logic [TIME_W-1:0] elapsed;
  logic [TIME_W-1:0] elapsedNext;
  logic [TIME_W-1:0] offset;

  assign elapsedNext = elapsed + TIME_W'(strobes.secStep);
  assign curTime     = offset + elapsed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed  <= '0;
      offset   <= RESET_OFFSET;
      secTick  <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      elapsed  <= elapsedNext;
      secTick  <= strobes.secStep;
      rspValid <= strobes.capture;
      // Subtract the post-edge count so the written value is reported
      // exactly, even when a boundary lands on the write cycle.
      if (strobes.loadOffset) begin
        offset <= setData - elapsedNext;
      end
      if (strobes.capture) begin
        rspData <= curTime;
      end
    end
  end

endmodule

// File: rtl/epoch_seconds_clock.sv
module epoch_seconds_clock
  import epoch_clk_pkg::*;
#(
  parameter int unsigned       TICKS_PER_SEC = 1000,
  parameter int unsigned       TIME_W        = 32,
  parameter logic [TIME_W-1:0] RESET_OFFSET  = TIME_W'(2082844800),
  localparam int unsigned      ARG_BYTES     = TIME_W / 8,
  localparam int unsigned      CNT_W         = $clog2(ARG_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              setStb,
  input  logic [CNT_W-1:0]  setCount,
  input  logic [TIME_W-1:0] setData,
  input  logic              getStb,
  input  logic [CNT_W-1:0]  getCount,
  output logic              secTick,
  output logic              rspValid,
  output logic [TIME_W-1:0] rspData
);

  clkStrobes_t       strobes;
  logic [TIME_W-1:0] curTime;

  epoch_clk_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .ARG_BYTES    (ARG_BYTES),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .setStb  (setStb),
    .setCount(setCount),
    .getStb  (getStb),
    .getCount(getCount),
    .strobes (strobes)
  );

  epoch_clk_datapath #(
    .TIME_W      (TIME_W),
    .RESET_OFFSET(RESET_OFFSET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .setData (setData),
    .secTick (secTick),
    .rspValid(rspValid),
    .rspData (rspData),
    .curTime (curTime)
  );

endmodule

// File: rtl/epoch_seconds_clock_checker.sv
module epoch_seconds_clock_checker #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned TIME_W        = 32,
  parameter int unsigned ARG_BYTES     = 4,
  parameter int unsigned CNT_W         = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              setStb,
  input logic [CNT_W-1:0]  setCount,
  input logic [TIME_W-1:0] setData,
  input logic              getStb,
  input logic [CNT_W-1:0]  getCount,
  input logic              secTick,
  input logic              rspValid,
  input logic [TIME_W-1:0] rspData,
  input logic [TIME_W-1:0] curTime
);

  logic setOk;
  assign setOk = setStb && (setCount == CNT_W'(ARG_BYTES));

  a_r2_tick_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> $past(tickEn));

  a_r2_tick_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (TICKS_PER_SEC > 1) && secTick |=> !secTick);

  a_r3_read_returns_time: assert property (@(posedge clk) disable iff (!rstN)
    getStb && (getCount == '0) |=> rspValid && (rspData == $past(curTime)));

  a_r4_bad_read_silent: assert property (@(posedge clk) disable iff (!rstN)
    getStb && (getCount != '0) |=> !rspValid && $stable(rspData));

  a_r5_write_takes_value: assert property (@(posedge clk) disable iff (!rstN)
    setOk |=> (curTime == $past(setData)));

  a_r10_time_follows_tick: assert property (@(posedge clk) disable iff (!rstN)
    !setOk |=> (curTime == $past(curTime) + TIME_W'(secTick)));

endmodule

bind epoch_seconds_clock epoch_seconds_clock_checker #(
  .TICKS_PER_SEC(TICKS_PER_SEC),
  .TIME_W       (TIME_W),
  .ARG_BYTES    (ARG_BYTES),
  .CNT_W        (CNT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .setStb  (setStb),
  .setCount(setCount),
  .setData (setData),
  .getStb  (getStb),
  .getCount(getCount),
  .secTick (secTick),
  .rspValid(rspValid),
  .rspData (rspData),
  .curTime (curTime)
);

// File: tb/epoch_seconds_clock_bench.sv
`timescale 1ns/1ps
module epoch_seconds_clock_bench;

  localparam int DIV = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        setStb = 1'b0;
  logic [2:0]  setCount = '0;
  logic [31:0] setData = '0;
  logic        getStb = 1'b0;
  logic [2:0]  getCount = '0;
  logic        secTick;
  logic        rspValid;
  logic [31:0] rspData;

  int          checks = 0;
  int          errors = 0;
  int          enTotal = 0;
  logic [31:0] timeModel;
  logic        finished = 1'b0;

  always #4 clk = ~clk;

  epoch_seconds_clock #(.TICKS_PER_SEC(DIV)) u_epoch_seconds_clock (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .setStb(setStb), .setCount(setCount), .setData(setData),
    .getStb(getStb), .getCount(getCount),
    .secTick(secTick), .rspValid(rspValid), .rspData(rspData)
  );

  // {setCount, setData, expected read-back}, applied with no ticking
  localparam logic [66:0] VEC [6] = '{
    {3'd4, 32'h1234_5678, 32'h1234_5678},
    {3'd3, 32'hAAAA_AAAA, 32'h1234_5678},
    {3'd4, 32'h0000_0000, 32'h0000_0000},
    {3'd5, 32'h5555_5555, 32'h0000_0000},
    {3'd0, 32'h7777_7777, 32'h0000_0000},
    {3'd4, 32'h89AB_CDEF, 32'h89AB_CDEF}
  };

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doSet(input logic [2:0] cnt, input logic [31:0] val);
    @(negedge clk);
    setStb = 1'b1; setCount = cnt; setData = val;
    @(negedge clk);
    setStb = 1'b0;
  endtask

  // Issue a read, sample the response one cycle later.
  task automatic doGet(input logic [2:0] cnt, output logic v, output logic [31:0] d);
    @(negedge clk);
    getStb = 1'b1; getCount = cnt;
    @(negedge clk);
    getStb = 1'b0;
    v = rspValid; d = rspData;
  endtask

  // Run n enabled cycles; optional accepted write at index setAt.
  task automatic runTicks(input int n, input int setAt, input logic [31:0] val,
                          input string req);
    int  bad = 0;
    logic expStep = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0 && secTick !== expStep) bad++;
      tickEn = 1'b1;
      setStb = (i == setAt); setCount = 3'd4; setData = val;
      enTotal++;
      expStep = (enTotal % DIV == 0);
      if (i == setAt) timeModel = val;
      else if (expStep) timeModel = timeModel + 1;
    end
    @(negedge clk);
    if (secTick !== expStep) bad++;
    tickEn = 1'b0; setStb = 1'b0;
    check(bad == 0, req, 32'(bad), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic        v;
    logic [31:0] d;
    logic [31:0] held;
    int          bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state and epoch offset
    check(secTick == 1'b0 && rspValid == 1'b0, "R1 reset outputs",
          {30'd0, secTick, rspValid}, 32'd0);
    doGet(3'd0, v, d);
    check(v == 1'b1, "R3 read valid", {31'd0, v}, 32'd1);
    check(d == 32'd2082844800, "R1 reset epoch", d, 32'd2082844800);
    @(negedge clk);
    check(rspValid == 1'b0, "R3 valid one cycle", {31'd0, rspValid}, 32'd0);

    // Table walk: R5 accepted writes, R6 rejected counts
    for (int i = 0; i < 6; i++) begin
      doSet(VEC[i][66:64], VEC[i][63:32]);
      doGet(3'd0, v, d);
      check(v && d == VEC[i][31:0], (VEC[i][66:64] == 3'd4) ? "R5 write" : "R6 rejected write",
            d, VEC[i][31:0]);
    end
    // R3: first byte sits in [31:24]
    check(d[31:24] == 8'h89, "R3 byte order", {24'd0, d[31:24]}, 32'h89);

    // R4: read with arguments is dropped
    held = d;
    doGet(3'd1, v, d);
    check(!v && d == held, "R4 read with args", {d[31:1], v}, {held[31:1], 1'b0});

    // R2 / R10: pulses every DIV enables, time steps once per pulse
    timeModel = 32'h89AB_CDEF;
    runTicks(3 * DIV, -1, 32'd0, "R2 pulse spacing");
    doGet(3'd0, v, d);
    check(d == timeModel, "R10 time after ticks", d, timeModel);

    // R2: gaps in tickEn pause the prescaler
    runTicks(2, -1, 32'd0, "R2 pause part a");
    repeat (7) @(negedge clk);
    check(secTick == 1'b0, "R2 no pulse while disabled", {31'd0, secTick}, 32'd0);
    runTicks(6, -1, 32'd0, "R2 pause part b");
    doGet(3'd0, v, d);
    check(d == timeModel, "R10 time after pause", d, timeModel);

    // R7: write mid-second keeps the pulse phase
    runTicks(12, 1 + ((DIV - 1 - enTotal % DIV) + 2) % DIV, 32'd1000, "R7 phase kept");
    doGet(3'd0, v, d);
    check(d == timeModel, "R7 time after write", d, timeModel);

    // R8: write on the boundary cycle
    runTicks(DIV + 1, (DIV - 1 - enTotal % DIV) % DIV, 32'd5000, "R8 boundary write pulses");
    doGet(3'd0, v, d);
    check(d == timeModel, "R8 boundary write value", d, timeModel);

    // R9: wrap from all ones
    doSet(3'd4, 32'hFFFF_FFFF);
    timeModel = 32'hFFFF_FFFF;
    bad = (DIV - enTotal % DIV) % DIV;
    runTicks(bad == 0 ? DIV : bad, -1, 32'd0, "R9 wrap pulses");
    doGet(3'd0, v, d);
    check(d == 32'd0 && timeModel == 32'd0, "R9 wrap to zero", d, 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule